// File: doc/BRIEF.md
# I2C Target Controller with Sticky Event Flags

This block lets a processor take part in an I2C bus as an addressed target. It watches the SCL and SDA lines through a synchronizer and finds START and STOP conditions. It compares the first byte of each transfer with a 7-bit own address, or with the general-call address when that is enabled. When the address matches it answers with ACK. After that it either takes in bytes written by the host or sends bytes the host reads. Software exchanges bytes through a one-byte data port.

Each bus event sets its own sticky flag in a status register. Software clears a flag by writing 0 to its bit. A mask register selects which flags drive the single interrupt output. The block gives byte-level flow control by holding SCL low in two cases: while a received byte (or the address byte) waits to be read, and while the next byte to send has not yet been written. A control bit makes the target answer received data bytes with NACK. Both bus lines are open-drain: the block only pulls a line low.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the control, status, interrupt-enable and own-address registers read 0, irq_o is 0, and neither sda_oe_o nor scl_oe_o is asserted.
- R2: The register offsets are: control at 0, status at 1, interrupt enable at 2, own address at 3 and the data port at 4. Control bits 3:0 read back as written and bits 7:4 read 0. Interrupt-enable bits 6:0 and own-address bits 6:0 read back as written and bit 7 reads 0.
- R3: With the interface enabled (control bit 2), an address byte whose upper seven bits equal the own address is ACKed: SDA is low during the ninth clock. This sets the address flag (status bit 0) and loads the transmit-mode bit (status bit 5) from the R/W bit.
- R4: If the address does not match, or the interface is disabled, the block gives no ACK and never pulls a line low. No status bit changes, including at the following STOP.
- R5: The all-zero write address is ACKed only while general-call enable (control bit 1) is set. It then sets status bit 6 together with status bit 0.
- R6: After a write-address match, the data port holds the address byte and SCL is held low until that byte is read (the dummy read). Each data byte written by the host then sets the received flag (status bit 1), and the data port returns that byte.
- R7: While forced NACK (control bit 0) is set, each received data byte is answered with NACK (SDA high in the ninth clock). The byte is still stored and still flagged.
- R8: On a read-address match, SCL is held low until software writes the data port. When the byte moves into the shifter, the transmit-empty flag (status bit 3) is set and SCL is released. The byte goes out MSB first. The host's acknowledge clock sets the transmitted flag (status bit 2).
- R9: After the ACK of a received byte, SCL is held low until the data port is read. After a host ACK on a sent byte, SCL is held low until a new byte is written.
- R10: A STOP after this target was addressed sets status bit 4, and the block releases both lines.
- R11: Writing the status register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R12: irq_o is high exactly when some status bit and the interrupt-enable bit at the same position are both 1.
- R13: Status bit 5 is read-only: writes do not change it. It changes only at an address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (a data-port read consumes the byte) |
| addr_i | input | AW | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
An internal state that has drifted out of step with the bus shows up at the pins within a single byte. It appears as an ACK on the wrong clock, a bit missing or shifted in the returned data, or SCL held when nothing is pending or released too early. Flag errors appear in the status register at once. A STOP that leaves the target driving a line, a read-only bit that a write changes, or an interrupt without a matching enabled flag all break a check within a cycle of the event. The host model answers SCL holding, so a hold that is never released ends the run at the watchdog.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned TA_W = 7;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_IEN  = 3'd2;
  localparam logic [2:0] OFS_OWN  = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;

  localparam int C_FNACK = 0;
  localparam int C_GCEN  = 1;
  localparam int C_EN    = 2;

  localparam int S_ADR  = 0;
  localparam int S_RXD  = 1;
  localparam int S_TXD  = 2;
  localparam int S_TXE  = 3;
  localparam int S_STOP = 4;
  localparam int S_TXM  = 5;
  localparam int S_GC   = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RWAIT, ST_RX,
    ST_RACK, ST_TLOAD, ST_TX, ST_TACK, ST_DONE
  } eng_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] pipe_q [STAGES];
  logic [1:0] prev_q;
  logic       scl_c, sda_c, scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      pipe_q[0] <= {scl_i, sda_i};
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign {scl_c, sda_c} = pipe_q[STAGES-1];
  assign {scl_p, sda_p} = prev_q;

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  // SDA edges while SCL stays high
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine import i2c_tgt_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            gc_en_i,
  input  logic            fnack_i,
  input  logic [TA_W-1:0] own_addr_i,
  input  logic            sda_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            rx_full_i,
  input  logic            tx_full_i,
  input  logic [DW-1:0]   tx_data_i,
  output logic            sda_oe_o,
  output logic            scl_oe_o,
  output logic            adr_ev_o,
  output logic            rw_o,
  output logic            gc_ev_o,
  output logic            rx_load_o,
  output logic            rxd_ev_o,
  output logic [DW-1:0]   rx_data_o,
  output logic            txe_ev_o,
  output logic            txd_ev_o,
  output logic            stop_ev_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  eng_state_e      st_q;
  logic [DW-1:0]   sh_q;
  logic [CW-1:0]   cnt_q;
  logic            ack_q, rw_q, mack_q, hit_q;
  logic            own_hit, gc_hit;

  assign own_hit = (sh_q[DW-1:1] == own_addr_i) && (sh_q[DW-1:1] != '0);
  assign gc_hit  = gc_en_i && (sh_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sh_q <= '0; cnt_q <= '0;
      ack_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0; hit_q <= 1'b0;
      adr_ev_o <= 1'b0; gc_ev_o <= 1'b0; rx_load_o <= 1'b0; rxd_ev_o <= 1'b0;
      txe_ev_o <= 1'b0; txd_ev_o <= 1'b0; stop_ev_o <= 1'b0;
    end else begin
      adr_ev_o <= 1'b0; gc_ev_o <= 1'b0; rx_load_o <= 1'b0; rxd_ev_o <= 1'b0;
      txe_ev_o <= 1'b0; txd_ev_o <= 1'b0; stop_ev_o <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE; ack_q <= 1'b0; hit_q <= 1'b0;
      end else if (start_i) begin
        st_q <= ST_ADDR; cnt_q <= '0; ack_q <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE; ack_q <= 1'b0; hit_q <= 1'b0;
        stop_ev_o <= hit_q;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_RX: begin
            if (rise_i) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == FULL) begin
              if (st_q == ST_RX) begin
                ack_q <= ~fnack_i; st_q <= ST_RACK;
                rx_load_o <= 1'b1; rxd_ev_o <= 1'b1;
              end else if (own_hit || gc_hit) begin
                ack_q <= 1'b1; st_q <= ST_AACK; hit_q <= 1'b1;
                rw_q <= sh_q[0]; adr_ev_o <= 1'b1; gc_ev_o <= gc_hit;
                rx_load_o <= ~sh_q[0];
              end else begin
                st_q <= ST_DONE;
              end
            end
          end
          ST_AACK: if (fall_i) begin
            ack_q <= 1'b0; cnt_q <= '0;
            st_q  <= rw_q ? ST_TLOAD : ST_RWAIT;
          end
          ST_RACK: if (fall_i) begin
            ack_q <= 1'b0; st_q <= ST_RWAIT;
          end
          ST_RWAIT: if (!rx_full_i) begin
            cnt_q <= '0; st_q <= ST_RX;
          end
          ST_TLOAD: if (tx_full_i) begin
            sh_q <= tx_data_i; cnt_q <= '0; txe_ev_o <= 1'b1; st_q <= ST_TX;
          end
          ST_TX: if (fall_i) begin
            if (cnt_q == LAST) st_q <= ST_TACK;
            else begin
              sh_q  <= {sh_q[DW-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TACK: begin
            if (rise_i) begin
              txd_ev_o <= 1'b1; mack_q <= ~sda_i;
            end else if (fall_i) begin
              st_q <= mack_q ? ST_TLOAD : ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rw_o      = rw_q;
  assign rx_data_o = sh_q;
  assign sda_oe_o  = ((st_q == ST_AACK || st_q == ST_RACK) && ack_q) ||
                     (st_q == ST_TX && !sh_q[DW-1]);
  // byte-level flow control
  assign scl_oe_o  = (st_q == ST_RWAIT && rx_full_i) ||
                     (st_q == ST_TLOAD && !tx_full_i);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs import i2c_tgt_pkg::*; #(
  parameter int unsigned AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            adr_ev_i,
  input  logic            rw_i,
  input  logic            gc_ev_i,
  input  logic            stop_ev_i,
  input  logic            txe_ev_i,
  input  logic            txd_ev_i,
  input  logic            rxd_ev_i,
  input  logic            rx_load_i,
  input  logic [DW-1:0]   rx_data_i,
  output logic            en_o,
  output logic            gc_en_o,
  output logic            fnack_o,
  output logic [TA_W-1:0] own_addr_o,
  output logic            rx_full_o,
  output logic            tx_full_o,
  output logic [DW-1:0]   tx_data_o,
  output logic [6:0]      status_o,
  output logic            irq_o
);
  logic [3:0]      ctrl_q;
  logic [6:0]      ien_q, flag_q, set_vec, keep;
  logic [TA_W-1:0] own_q;
  logic            stm_q;
  logic [DW-1:0]   rx_q;
  logic            w_ctrl, w_stat, w_ien, w_own, w_data, r_data;

  assign w_ctrl = we_i && addr_i == AW'(OFS_CTRL);
  assign w_stat = we_i && addr_i == AW'(OFS_STAT);
  assign w_ien  = we_i && addr_i == AW'(OFS_IEN);
  assign w_own  = we_i && addr_i == AW'(OFS_OWN);
  assign w_data = we_i && addr_i == AW'(OFS_DATA);
  assign r_data = re_i && addr_i == AW'(OFS_DATA);

  always_comb begin
    set_vec         = '0;
    set_vec[S_ADR]  = adr_ev_i;
    set_vec[S_RXD]  = rxd_ev_i;
    set_vec[S_TXD]  = txd_ev_i;
    set_vec[S_TXE]  = txe_ev_i;
    set_vec[S_STOP] = stop_ev_i;
    set_vec[S_GC]   = gc_ev_i;
    keep            = w_stat ? wdata_i[6:0] : '1;
    keep[S_TXM]     = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; ien_q <= '0; own_q <= '0; flag_q <= '0; stm_q <= 1'b0;
      rx_q <= '0; tx_data_o <= '0; rx_full_o <= 1'b0; tx_full_o <= 1'b0;
    end else begin
      if (w_ctrl) ctrl_q <= wdata_i[3:0];
      if (w_ien)  ien_q  <= wdata_i[6:0];
      if (w_own)  own_q  <= wdata_i[TA_W-1:0];
      flag_q <= (flag_q & keep) | set_vec;  // new event wins over a clear
      if (adr_ev_i) stm_q <= rw_i;
      if (rx_load_i) begin
        rx_q <= rx_data_i; rx_full_o <= 1'b1;
      end else if (r_data) rx_full_o <= 1'b0;
      if (w_data) begin
        tx_data_o <= wdata_i; tx_full_o <= 1'b1;
      end else if (txe_ev_i) tx_full_o <= 1'b0;
    end
  end

  always_comb begin
    status_o        = flag_q;
    status_o[S_TXM] = stm_q;
  end

  always_comb begin
    unique case (addr_i)
      AW'(OFS_CTRL): rdata_o = {4'b0, ctrl_q};
      AW'(OFS_STAT): rdata_o = {1'b0, status_o};
      AW'(OFS_IEN):  rdata_o = {1'b0, ien_q};
      AW'(OFS_OWN):  rdata_o = {1'b0, own_q};
      AW'(OFS_DATA): rdata_o = rx_q;
      default:       rdata_o = '0;
    endcase
  end

  assign en_o       = ctrl_q[C_EN];
  assign gc_en_o    = ctrl_q[C_GCEN];
  assign fnack_o    = ctrl_q[C_FNACK];
  assign own_addr_o = own_q;
  assign irq_o      = |(status_o & ien_q);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl import i2c_tgt_pkg::*; #(
  parameter int unsigned AW          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          irq_o
);
  logic sda_s, rise, fall, start, stop;
  logic en, gc_en, fnack, rx_full, tx_full;
  logic adr_ev, rw, gc_ev, rx_load, rxd_ev, txe_ev, txd_ev, stop_ev;
  logic [TA_W-1:0] own_addr;
  logic [DW-1:0]   rx_data, tx_data;
  logic [6:0]      status;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_engine u_eng (
    .clk_i, .rst_ni, .en_i(en), .gc_en_i(gc_en), .fnack_i(fnack),
    .own_addr_i(own_addr), .sda_i(sda_s), .rise_i(rise), .fall_i(fall),
    .start_i(start), .stop_i(stop), .rx_full_i(rx_full), .tx_full_i(tx_full),
    .tx_data_i(tx_data), .sda_oe_o, .scl_oe_o, .adr_ev_o(adr_ev), .rw_o(rw),
    .gc_ev_o(gc_ev), .rx_load_o(rx_load), .rxd_ev_o(rxd_ev), .rx_data_o(rx_data),
    .txe_ev_o(txe_ev), .txd_ev_o(txd_ev), .stop_ev_o(stop_ev)
  );

  i2c_tgt_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o,
    .adr_ev_i(adr_ev), .rw_i(rw), .gc_ev_i(gc_ev), .stop_ev_i(stop_ev),
    .txe_ev_i(txe_ev), .txd_ev_i(txd_ev), .rxd_ev_i(rxd_ev),
    .rx_load_i(rx_load), .rx_data_i(rx_data), .en_o(en), .gc_en_o(gc_en),
    .fnack_o(fnack), .own_addr_o(own_addr), .rx_full_o(rx_full),
    .tx_full_o(tx_full), .tx_data_o(tx_data), .status_o(status), .irq_o
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk import i2c_tgt_pkg::*; #(
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          wbit0_i,
  input logic          irq_o,
  input logic          sda_oe_o,
  input logic          scl_oe_o,
  input logic          en,
  input logic          adr_ev,
  input logic          stop_ev,
  input logic          txe_ev,
  input logic          tx_full,
  input logic [6:0]    status
);
  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |-> (!sda_oe_o && !scl_oe_o));

  // R4
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en) |-> (!sda_oe_o && !scl_oe_o));

  // R11
  w0c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_STAT) && !wbit0_i && !adr_ev) |=> !status[S_ADR]);

  // R13
  txm_readonly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status[S_TXM]) |-> $past(adr_ev));

  // R8
  tx_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_ev |-> $past(tx_full));

  // R12
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0));

  // R9
  hold_sda_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !sda_oe_o);
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wbit0_i(wdata_i[0]), .irq_o(irq_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o),
  .en(en), .adr_ev(adr_ev), .stop_ev(stop_ev), .txe_ev(txe_ev),
  .tx_full(tx_full), .status(status)
);

// File: tb/test_i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module test_i2c_tgt_ctrl;
  localparam int Q = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  wire  scl_line = host_scl & ~scl_oe;
  wire  sda_line = host_sda & ~sda_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  i2c_tgt_ctrl i_i2c_tgt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic scl_up();
    host_scl = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(); scl_up(); wq();
    host_sda = 1'b0; wq(); host_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(); scl_up(); wq();
    host_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(); scl_up(); wq(2 * Q); host_scl = 1'b0; wq();
    end
    host_sda = 1'b1; wq(); scl_up(); wq(); ack = sda_line; wq();
    host_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      host_sda = 1'b1; wq(); scl_up(); wq(); b[i] = sda_line; wq();
      host_scl = 1'b0; wq();
    end
    host_sda = ack; wq(); scl_up(); wq(2 * Q); host_scl = 1'b0; wq();
    host_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    expect_reg(3'd0, 8'h00, "R1 ctrl");
    expect_reg(3'd1, 8'h00, "R1 status");
    expect_reg(3'd2, 8'h00, "R1 ien");
    expect_reg(3'd3, 8'h00, "R1 own");
  endtask

  task automatic t_regs();
    wr(3'd0, 8'hFB); expect_reg(3'd0, 8'h0B, "R2 ctrl");
    wr(3'd2, 8'hFF); expect_reg(3'd2, 8'h7F, "R2 ien");
    wr(3'd3, 8'hFF); expect_reg(3'd3, 8'h7F, "R2 own");
    wr(3'd1, 8'hFF); expect_reg(3'd1, 8'h00, "R13 status not settable");
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h2A);
  endtask

  task automatic t_miss();
    logic ack;
    wr(3'd0, 8'h04);
    bus_start(); send_byte(8'h60, ack);
    chk(ack == 1'b1, "R4 foreign address nack", ack, 1);
    bus_stop(); expect_reg(3'd1, 8'h00, "R4 status after foreign stop");
    wr(3'd0, 8'h00);
    bus_start(); send_byte(8'h54, ack);
    chk(ack == 1'b1, "R4 disabled nack", ack, 1);
    bus_stop(); expect_reg(3'd1, 8'h00, "R4 status disabled");
  endtask

  task automatic t_write();
    logic ack; logic [7:0] d;
    wr(3'd0, 8'h04);
    bus_start(); send_byte(8'h54, ack);
    chk(ack == 1'b0, "R3 own address ack", ack, 0);
    expect_reg(3'd1, 8'h01, "R3 addr flag, txm=0");
    chk(scl_oe == 1'b1, "R6 hold before dummy read", scl_oe, 1);
    rd(3'd4, d); chk(d == 8'h54, "R6 dummy read byte", d, 8'h54);
    wq(2); chk(scl_oe == 1'b0, "R6 release after dummy read", scl_oe, 0);
    wr(3'd1, 8'hFE); expect_reg(3'd1, 8'h00, "R11 clear addr flag");
    send_byte(8'hA5, ack);
    chk(ack == 1'b0, "R6 data ack", ack, 0);
    expect_reg(3'd1, 8'h02, "R6 rx flag");
    chk(scl_oe == 1'b1, "R9 hold after rx byte", scl_oe, 1);
    rd(3'd4, d); chk(d == 8'hA5, "R6 rx byte 1", d, 8'hA5);
    wq(2); chk(scl_oe == 1'b0, "R9 release after read", scl_oe, 0);
    send_byte(8'h3C, ack);
    rd(3'd4, d); chk(d == 8'h3C, "R6 rx byte 2", d, 8'h3C);
    bus_stop();
    chk(!scl_oe && !sda_oe, "R10 lines free", {scl_oe, sda_oe}, 0);
    expect_reg(3'd1, 8'h12, "R10 stop flag");
    wr(3'd2, 8'h10); wq(2); chk(irq == 1'b1, "R12 irq on enabled stop", irq, 1);
    wr(3'd2, 8'h01); wq(2); chk(irq == 1'b0, "R12 no irq for unset flag", irq, 0);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'hEF); expect_reg(3'd1, 8'h02, "R11 clear only stop");
    wr(3'd1, 8'hFF); expect_reg(3'd1, 8'h02, "R11 ones keep");
    wr(3'd1, 8'hFD); expect_reg(3'd1, 8'h00, "R11 clear rx");
  endtask

  task automatic t_fnack();
    logic ack; logic [7:0] d;
    wr(3'd0, 8'h05);
    bus_start(); send_byte(8'h54, ack);
    chk(ack == 1'b0, "R7 address still acked", ack, 0);
    rd(3'd4, d);
    send_byte(8'h11, ack);
    chk(ack == 1'b1, "R7 forced nack", ack, 1);
    expect_reg(3'd1, 8'h03, "R7 byte flagged");
    rd(3'd4, d); chk(d == 8'h11, "R7 byte stored", d, 8'h11);
    bus_stop(); wr(3'd0, 8'h04); wr(3'd1, 8'h00);
  endtask

  task automatic t_gc();
    logic ack; logic [7:0] d;
    bus_start(); send_byte(8'h00, ack);
    chk(ack == 1'b1, "R5 general call off", ack, 1);
    bus_stop(); expect_reg(3'd1, 8'h00, "R5 no flags when off");
    wr(3'd0, 8'h06);
    bus_start(); send_byte(8'h00, ack);
    chk(ack == 1'b0, "R5 general call ack", ack, 0);
    expect_reg(3'd1, 8'h41, "R5 gc and addr flags");
    rd(3'd4, d); bus_stop();
    wr(3'd1, 8'h00); wr(3'd0, 8'h04);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] d;
    bus_start(); send_byte(8'h55, ack);
    chk(ack == 1'b0, "R3 read address ack", ack, 0);
    expect_reg(3'd1, 8'h21, "R3 addr flag with txm=1");
    chk(scl_oe == 1'b1, "R8 hold until data", scl_oe, 1);
    wr(3'd4, 8'hC3); wq(4);
    chk(scl_oe == 1'b0, "R8 release after load", scl_oe, 0);
    expect_reg(3'd1, 8'h29, "R8 tx empty flag");
    recv_byte(1'b0, d);
    chk(d == 8'hC3, "R8 byte 1 msb first", d, 8'hC3);
    expect_reg(3'd1, 8'h2D, "R8 transmitted flag");
    chk(scl_oe == 1'b1, "R9 hold for next tx byte", scl_oe, 1);
    wr(3'd4, 8'h5A); wq(4);
    recv_byte(1'b1, d);
    chk(d == 8'h5A, "R8 byte 2", d, 8'h5A);
    bus_stop();
    expect_reg(3'd1, 8'h3D, "R10 stop after read");
    wr(3'd1, 8'h00);
    expect_reg(3'd1, 8'h20, "R13 txm survives write 0");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_regs();
    t_miss();
    t_write();
    t_fnack();
    t_gc();
    t_read();
    t_write();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule